// File: doc/BRIEF.md
# Debug Bus Access Engine

This block lets a debug host run one read or one write on a 32-bit system bus. The host loads a target address and a data word through a small register port. It then writes a control word that gives the transfer size and direction and sets a start flag. The engine checks the alignment and runs a single request/ready handshake on the bus. It moves the data between the right-justified register format and the byte lanes that the address selects.

Completion is reported through a two-bit status pair, err and dv. Their meaning depends on direction. During a read, 0,0 means pending and 0,1 means valid data has arrived. During a write, 0,1 means in flight and 0,0 means done. The value 1,0 always means a failure, and 1,1 is never produced. The host polls the control register until the pair shows the outcome it expects.

Top module: `dba_top`

## Requirements
- R1: After reset the address, data and control registers all read as zero and no bus request is driven.
- R2: Host register indices are 0x9 for the address, 0xA for the data and 0xB for control. The address and data registers read back what was written. The control word holds start in bit 0, size in bits 3:1 and read (1) / write (0) in bit 4. On reads it returns err in bit 8, dv in bit 9 and busy in bit 10. Any other index reads zero.
- R3: A control write with bit 0 set launches exactly one bus transfer, and bit 0 always reads 0. While a transfer is busy, host writes to all three registers are ignored.
- R4: Size code 000 is a byte at any offset, 001 a halfword with address bit 0 = 0, and 010 a word with address bits 1:0 = 00. An unused code or a misaligned address sets err=1, dv=0 on the start edge, and no bus request follows.
- R5: On a write, the low bytes of the data register appear on the lanes that start at address bits 1:0, with lane 0 = bits 7:0 (little-endian). The 4-bit byte enable marks exactly those lanes.
- R6: On a read, the addressed lanes are captured right-justified into the data register, with the unused upper bits zero. err,dv reads 0,0 while pending and 0,1 once ready is sampled.
- R7: During a write, err,dv reads 0,1 while the request is outstanding and 0,0 after ready is sampled without error.
- R8: An error sampled with ready gives err,dv = 1,0 for either direction, and a failed read leaves the data register unchanged.
- R9: err and dv are never 1 at the same time.
- R10: A request stays asserted, with stable address, byte enable, write flag and write data, until ready is sampled. It drops in the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Host register write strobe |
| reg_idx_i | input | 4 | Host register index |
| reg_wdata_i | input | 32 | Host write data |
| reg_rdata_o | output | 32 | Host read data for reg_idx_i (combinational) |
| bus_req_o | output | 1 | Bus request |
| bus_we_o | output | 1 | 1 = write cycle |
| bus_addr_o | output | 32 | Byte address |
| bus_be_o | output | 4 | Byte enables, bit n = bits 8n+7:8n |
| bus_wdata_o | output | 32 | Lane-steered write data |
| bus_rdata_i | input | 32 | Read data from bus |
| bus_ready_i | input | 1 | Transfer completes in this cycle |
| bus_err_i | input | 1 | Error response, valid with ready |

## Verification
Some properties are checked on every cycle:
- err and dv are never both set.
- A request is held, with stable address and byte enable, until ready, and it drops right after.
- The byte-enable count matches the size.
- A rejected start produces err and no request.

Other behaviour needs the directed scenarios. These include the exact lane placement and the right-justified capture for each size and offset. They also include the direction-dependent meaning of the status pair, the unchanged data register after a failed read, and the fact that register writes and a second start arriving mid-transfer leave no trace.

// File: rtl/dba_pkg.sv
package dba_pkg;
  localparam int REG_IDX_W = 4;
  localparam logic [REG_IDX_W-1:0] IDX_ADDR = 4'h9;
  localparam logic [REG_IDX_W-1:0] IDX_DATA = 4'hA;
  localparam logic [REG_IDX_W-1:0] IDX_CTRL = 4'hB;

  localparam logic [2:0] SZ_BYTE = 3'b000;
  localparam logic [2:0] SZ_HALF = 3'b001;
  localparam logic [2:0] SZ_WORD = 3'b010;

  // control word bit positions
  localparam int CB_START = 0;
  localparam int CB_SIZE  = 1;
  localparam int CB_READ  = 4;
  localparam int CB_ERR   = 8;
  localparam int CB_DV    = 9;
  localparam int CB_BUSY  = 10;

  typedef enum logic {ST_IDLE, ST_BUS} dba_state_e;
endpackage

// File: rtl/dba_lane_steer.sv
module dba_lane_steer #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [2:0]        size_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              legal_o,
  output logic [LANES-1:0]  be_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rdata_o
);
  import dba_pkg::*;

  logic [OFF_W:0]    nbytes;
  logic [OFF_W-1:0]  align_mask;
  logic [DATA_W-1:0] wshift, rshift;

  assign nbytes     = (OFF_W+1)'(1) << size_i[1:0];
  assign align_mask = OFF_W'(nbytes - 1'b1);
  assign legal_o    = (size_i <= SZ_WORD) && ((off_i & align_mask) == '0);
  assign wshift     = data_i << {off_i, 3'b000};
  assign rshift     = bus_rdata_i >> {off_i, 3'b000};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign be_o[i] = (int'(off_i) <= i) && (i < int'(off_i) + int'(nbytes));
    assign wdata_o[8*i +: 8] = be_o[i] ? wshift[8*i +: 8] : 8'h00;
    assign rdata_o[8*i +: 8] = (i < int'(nbytes)) ? rshift[8*i +: 8] : 8'h00;
  end
endmodule

// File: rtl/dba_ctrl.sv
module dba_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic legal_i,
  input  logic is_read_i,
  input  logic bus_ready_i,
  input  logic bus_err_i,
  output logic busy_o,
  output logic bus_req_o,
  output logic err_o,
  output logic dv_o,
  output logic capture_o
);
  import dba_pkg::*;

  dba_state_e state_q;

  assign busy_o    = (state_q == ST_BUS);
  assign bus_req_o = busy_o;
  assign capture_o = busy_o && bus_ready_i && !bus_err_i && is_read_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      err_o   <= 1'b0;
      dv_o    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          if (legal_i) begin
            state_q <= ST_BUS;
            err_o   <= 1'b0;
            dv_o    <= !is_read_i; // write in flight reads as 0,1
          end else begin
            err_o   <= 1'b1;
            dv_o    <= 1'b0;
          end
        end
        ST_BUS: if (bus_ready_i) begin
          state_q <= ST_IDLE;
          err_o   <= bus_err_i;
          dv_o    <= !bus_err_i && is_read_i;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_no_err_dv_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(err_o && dv_o));
  assert_req_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ready_i |=> bus_req_o);
  assert_req_drop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_ready_i |=> !bus_req_o);
  assert_illegal_no_bus_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && start_i && !legal_i |=> !bus_req_o && err_o && !dv_o);
  assert_bus_err_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_ready_i && bus_err_i |=> err_o && !dv_o);
endmodule

// File: rtl/dba_top.sv
module dba_top #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [3:0]        reg_idx_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [LANES-1:0]  bus_be_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_ready_i,
  input  logic              bus_err_i
);
  import dba_pkg::*;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [2:0]        size_q;
  logic              rd_q;
  logic              busy, err, dv, capture, legal;
  logic              ctrl_wr, start;
  logic [2:0]        size_sel;
  logic              rd_sel;
  logic [DATA_W-1:0] rdata_rj;

  assign ctrl_wr  = reg_wr_i && (reg_idx_i == IDX_CTRL) && !busy;
  assign start    = ctrl_wr && reg_wdata_i[CB_START];
  assign size_sel = ctrl_wr ? reg_wdata_i[CB_SIZE +: 3] : size_q;
  assign rd_sel   = ctrl_wr ? reg_wdata_i[CB_READ] : rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      data_q <= '0;
      size_q <= '0;
      rd_q   <= 1'b0;
    end else begin
      if (reg_wr_i && !busy && reg_idx_i == IDX_ADDR) addr_q <= ADDR_W'(reg_wdata_i);
      if (reg_wr_i && !busy && reg_idx_i == IDX_DATA) data_q <= DATA_W'(reg_wdata_i);
      else if (capture)                               data_q <= rdata_rj;
      if (ctrl_wr) begin
        size_q <= size_sel;
        rd_q   <= rd_sel;
      end
    end
  end

  dba_lane_steer #(.DATA_W(DATA_W)) u_steer (
    .size_i      (size_sel),
    .off_i       (addr_q[OFF_W-1:0]),
    .data_i      (data_q),
    .bus_rdata_i (bus_rdata_i),
    .legal_o     (legal),
    .be_o        (bus_be_o),
    .wdata_o     (bus_wdata_o),
    .rdata_o     (rdata_rj)
  );

  dba_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .legal_i     (legal),
    .is_read_i   (rd_sel),
    .bus_ready_i (bus_ready_i),
    .bus_err_i   (bus_err_i),
    .busy_o      (busy),
    .bus_req_o   (bus_req_o),
    .err_o       (err),
    .dv_o        (dv),
    .capture_o   (capture)
  );

  assign bus_addr_o = addr_q;
  assign bus_we_o   = !rd_q;

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_idx_i)
      IDX_ADDR: reg_rdata_o = 32'(addr_q);
      IDX_DATA: reg_rdata_o = 32'(data_q);
      IDX_CTRL: begin
        reg_rdata_o[CB_SIZE +: 3] = size_q;
        reg_rdata_o[CB_READ]      = rd_q;
        reg_rdata_o[CB_ERR]       = err;
        reg_rdata_o[CB_DV]        = dv;
        reg_rdata_o[CB_BUSY]      = busy;
      end
      default: reg_rdata_o = '0;
    endcase
  end

  assert_req_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ready_i |=> $stable(bus_addr_o) && $stable(bus_be_o)
                                  && $stable(bus_we_o) && $stable(bus_wdata_o));
  assert_be_count_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> $countones(bus_be_o) == (32'd1 << size_q));
  assert_data_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_we_o && bus_ready_i && bus_err_i |=> $stable(data_q));
endmodule

// File: tb/dba_top_tb_top.sv
`timescale 1ns/1ps
module dba_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_idx = 4'h0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        bus_req, bus_we;
  logic [31:0] bus_addr, bus_wdata;
  logic [3:0]  bus_be;
  logic [31:0] bus_rdata = '0;
  logic        bus_ready = 1'b0;
  logic        bus_err = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dba_top dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(reg_wr), .reg_idx_i(reg_idx), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr), .bus_be_o(bus_be),
    .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata), .bus_ready_i(bus_ready), .bus_err_i(bus_err)
  );

  localparam logic [31:0] ERRB = 32'h100, DVB = 32'h200, BUSYB = 32'h400;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_idx = idx; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic host_rd(input logic [3:0] idx, output logic [31:0] d);
    reg_idx = idx;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic respond(input int waits, input logic [31:0] rd, input logic er);
    repeat (waits) @(negedge clk);
    bus_ready = 1'b1; bus_rdata = rd; bus_err = er;
    @(negedge clk);
    bus_ready = 1'b0; bus_err = 1'b0; bus_rdata = '0;
  endtask

  function automatic logic [31:0] ctl(input logic [2:0] sz, input logic rd, input logic st);
    return 32'(st) | (32'(sz) << 1) | (32'(rd) << 4);
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    host_rd(4'h9, v); chk("R1 addr", v, 0);
    host_rd(4'hA, v); chk("R1 data", v, 0);
    host_rd(4'hB, v); chk("R1 ctrl", v, 0);
    chk("R1 req", 32'(bus_req), 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    host_wr(4'h9, 32'h1234_5678); host_rd(4'h9, v); chk("R2 addr rb", v, 32'h1234_5678);
    host_wr(4'hA, 32'hDEAD_BEEF); host_rd(4'hA, v); chk("R2 data rb", v, 32'hDEAD_BEEF);
    host_wr(4'hB, ctl(3'd1, 1'b1, 1'b0)); host_rd(4'hB, v); chk("R2 ctrl rb", v, 32'h12);
    host_rd(4'h3, v); chk("R2 other idx", v, 0);
    chk("R2 no start no req", 32'(bus_req), 0);
  endtask

  task automatic t_write(input string tag, input logic [31:0] a, input logic [31:0] d,
                         input logic [2:0] sz, input logic [3:0] be, input logic [31:0] wd);
    logic [31:0] v;
    host_wr(4'h9, a); host_wr(4'hA, d);
    host_wr(4'hB, ctl(sz, 1'b0, 1'b1));
    chk({tag, " R3 req"}, 32'(bus_req), 1);
    chk({tag, " R5 be"}, 32'(bus_be), 32'(be));
    chk({tag, " R5 wdata"}, bus_wdata, wd);
    chk({tag, " R5 we"}, 32'(bus_we), 1);
    host_rd(4'hB, v); chk({tag, " R7 inflight 0,1"}, v, BUSYB | DVB | (32'(sz) << 1));
    chk({tag, " R3 start reads 0"}, 32'(v[0]), 0);
    repeat (2) @(negedge clk);
    chk({tag, " R10 held"}, 32'(bus_req), 1);
    chk({tag, " R10 addr stable"}, bus_addr, a);
    respond(0, 32'h0, 1'b0);
    chk({tag, " R10 drop"}, 32'(bus_req), 0);
    host_rd(4'hB, v); chk({tag, " R7 done 0,0"}, v, 32'(sz) << 1);
    @(negedge clk);
    chk({tag, " R3 one xfer"}, 32'(bus_req), 0);
  endtask

  task automatic t_read(input string tag, input logic [31:0] a, input logic [2:0] sz,
                        input logic [31:0] bus_d, input logic [3:0] be, input logic [31:0] exp);
    logic [31:0] v;
    host_wr(4'h9, a); host_wr(4'hA, 32'hFFFF_FFFF);
    host_wr(4'hB, ctl(sz, 1'b1, 1'b1));
    chk({tag, " R6 we"}, 32'(bus_we), 0);
    chk({tag, " R5 be"}, 32'(bus_be), 32'(be));
    host_rd(4'hB, v); chk({tag, " R6 pending 0,0"}, v, BUSYB | 32'h10 | (32'(sz) << 1));
    respond(1, bus_d, 1'b0);
    host_rd(4'hB, v); chk({tag, " R6 dv 0,1"}, v, DVB | 32'h10 | (32'(sz) << 1));
    host_rd(4'hA, v); chk({tag, " R6 data"}, v, exp);
  endtask

  task automatic t_illegal(input string tag, input logic [31:0] a, input logic [2:0] sz);
    logic [31:0] v;
    host_wr(4'h9, a);
    host_wr(4'hB, ctl(sz, 1'b0, 1'b1));
    host_rd(4'hB, v); chk({tag, " R4 err"}, v, ERRB | (32'(sz) << 1));
    chk({tag, " R4 no req"}, 32'(bus_req), 0);
    repeat (3) @(negedge clk);
    chk({tag, " R4 still no req"}, 32'(bus_req), 0);
  endtask

  task automatic t_bus_err();
    logic [31:0] v;
    host_wr(4'h9, 32'h8000_0000); host_wr(4'hA, 32'h0000_5A5A);
    host_wr(4'hB, ctl(3'd2, 1'b1, 1'b1));
    respond(0, 32'h1111_1111, 1'b1);
    host_rd(4'hB, v); chk("R8 read err 1,0", v, ERRB | 32'h10 | 32'h4);
    host_rd(4'hA, v); chk("R8 data kept", v, 32'h0000_5A5A);
    host_wr(4'hB, ctl(3'd2, 1'b0, 1'b1));
    respond(2, 32'h0, 1'b1);
    host_rd(4'hB, v); chk("R8 write err 1,0", v, ERRB | 32'h4);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v;
    host_wr(4'h9, 32'h0000_6000); host_wr(4'hA, 32'h0000_0055);
    host_wr(4'hB, ctl(3'd2, 1'b0, 1'b1));
    host_wr(4'hB, ctl(3'd0, 1'b1, 1'b1));
    host_wr(4'h9, 32'h0000_7777);
    host_wr(4'hA, 32'h0000_0099);
    chk("R3 busy addr kept on bus", bus_addr, 32'h0000_6000);
    chk("R3 busy wdata kept", bus_wdata, 32'h0000_0055);
    chk("R3 busy we kept", 32'(bus_we), 1);
    respond(0, 32'hAAAA_AAAA, 1'b0);
    @(negedge clk);
    chk("R3 no second xfer", 32'(bus_req), 0);
    host_rd(4'hB, v); chk("R3 ctrl unchanged", v, 32'h4);
    host_rd(4'h9, v); chk("R3 addr reg unchanged", v, 32'h0000_6000);
    host_rd(4'hA, v); chk("R3 data reg unchanged", v, 32'h0000_0055);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_write("byte", 32'h0000_1003, 32'h0000_00AB, 3'd0, 4'b1000, 32'hAB00_0000);
    t_write("half", 32'h0000_2002, 32'hCAFE_BEEF, 3'd1, 4'b1100, 32'hBEEF_0000);
    t_write("word", 32'h0000_3000, 32'h1122_3344, 3'd2, 4'b1111, 32'h1122_3344);
    t_read("rbyte", 32'h0000_4001, 3'd0, 32'hDDCC_BBAA, 4'b0010, 32'h0000_00BB);
    t_read("rhalf", 32'h0000_4002, 3'd1, 32'hDDCC_BBAA, 4'b1100, 32'h0000_DDCC);
    t_read("rword", 32'h0000_4000, 3'd2, 32'hDDCC_BBAA, 4'b1111, 32'hDDCC_BBAA);
    t_illegal("half odd", 32'h0000_5001, 3'd1);
    t_illegal("word off2", 32'h0000_5002, 3'd2);
    t_illegal("size 3", 32'h0000_5000, 3'd3);
    t_bus_err();
    t_busy_ignore();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // R9 also watched from the ports on every cycle
  always @(negedge clk) if (rst_n && !done) begin
    if (reg_rdata[9] && reg_rdata[8] && reg_idx == 4'hB) begin
      checks++; errors++;
      $display("FAIL R9 actual=%h expected=err and dv not both set", reg_rdata);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule